// File: doc/BRIEF.md
# DMA Descriptor Chain Walker

The block follows a linked sequence of fixed-size DMA descriptors held in system memory and keeps a record of the descriptor it finished most recently. Software loads a start address and gives a start pulse. The walker then fetches each descriptor as two consecutive 32-bit reads and looks at the two top bits of the first word to decide what kind of entry it is.

A data entry causes a buffer transfer, which an external engine carries out through a start/done pulse pair. After the transfer the walker writes the entry's first word back with a completion flag set, then moves on to the entry eight bytes further along. A link entry sends the walk to the address held in its second word. An end entry stops the walk. The record register gets a data entry's address once that entry's write-back has been accepted, and gets a link entry's own address as soon as the link is read. Transmit and receive paths each use their own instance.

Top module: `desc_chain_walker`

## Requirements
- R1: After reset the last-descriptor output is 0x0000_0000, busy and done are low, and no memory request or transfer start is driven.
- R2: A start pulse while idle loads the base address. The first memory read is at the base address and the second is at base + 4, and each descriptor is fetched as word 0 followed by word 1.
- R3: Bit 31 of word 0 is the type bit and bit 30 is the end bit. With bit 31 clear the entry is a data entry whatever bit 30 holds, and one transfer start pulse is issued carrying word 1 as the buffer address.
- R4: After the transfer done pulse, a data entry gets exactly one memory write to its own address. The write data is the fetched word 0 with bit 29 set.
- R5: After a data entry's write-back, the next descriptor is fetched at that entry's address + 8.
- R6: The last-descriptor output takes a data entry's address only after that entry's write-back has been accepted, and never before.
- R7: A link entry (bit 31 set, bit 30 clear) causes no transfer and no write. The last-descriptor output takes the link entry's own address, and the next fetch is at word 1.
- R8: An end entry (bits 31 and 30 both set) halts the walk. Busy falls, done is high for exactly one cycle, and the last-descriptor output keeps its previous value.
- R9: A start pulse while busy is ignored, and the walk in progress continues unchanged.
- R10: A memory request that is not accepted stays asserted with a stable address until it is accepted.
- R11: Busy is high from the cycle after an accepted start until the halt. While busy is low no memory request and no transfer start is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse; acted on only when idle |
| base_addr_i | input | 32 | First descriptor address, captured on start |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle pulse when the walk halts |
| last_desc_o | output | 32 | Address of the most recently completed descriptor |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_req_write_o | output | 1 | High for a write, low for a read |
| mem_req_addr_o | output | 32 | Memory byte address |
| mem_req_wdata_o | output | 32 | Write-back data |
| mem_rsp_valid_i | input | 1 | Read data strobe |
| mem_rsp_data_i | input | 32 | Read data |
| xfer_start_o | output | 1 | Transfer engine start pulse |
| xfer_addr_o | output | 32 | Buffer address for the transfer |
| xfer_done_i | input | 1 | Transfer engine completion pulse |

## Verification
The walker is driven with chains of several shapes. A purely sequential run of data entries shows the +8 step and the write-back order. A chain with a link in the middle shows that the jump is taken and that the link's own address is recorded. A chain made only of links tells link recording apart from data recording. A chain whose first entry is the end marker shows that the record is left alone. One data entry has the end bit set with the type bit clear, which separates "type decides" from "end bit decides". A second start issued in the middle of a walk, a rerun over descriptors that were already written back, and a memory port that stalls irregularly show that requests and the walk order hold up under back-pressure.

// File: rtl/dcw_pkg.sv
package dcw_pkg;

    typedef enum logic [3:0] {
        WS_IDLE,
        WS_RD0_REQ,
        WS_RD0_WAIT,
        WS_RD1_REQ,
        WS_RD1_WAIT,
        WS_XFER_GO,
        WS_XFER_WAIT,
        WS_WB_REQ
    } walk_state_t;

    typedef enum logic [1:0] {
        KIND_DATA,
        KIND_LINK,
        KIND_END
    } desc_kind_t;

endpackage

// File: rtl/dcw_decode.sv
module dcw_decode
    import dcw_pkg::*;
(
    input  logic       type_bit_i,
    input  logic       end_bit_i,
    output desc_kind_t kind_o
);

    // The end bit only counts when the type bit marks a control entry.
    always_comb begin
        if (!type_bit_i) begin
            kind_o = KIND_DATA;
        end else if (end_bit_i) begin
            kind_o = KIND_END;
        end else begin
            kind_o = KIND_LINK;
        end
    end

endmodule

// File: rtl/dcw_next_ptr.sv
module dcw_next_ptr #(
    parameter int WORD_W       = 32,
    parameter int STRIDE_BYTES = 8
) (
    input  logic [WORD_W-1:0] cur_i,
    input  logic [WORD_W-1:0] link_i,
    input  logic              take_link_i,
    output logic [WORD_W-1:0] next_o,
    output logic [WORD_W-1:0] word1_addr_o
);

    localparam int WORD_BYTES = WORD_W / 8;
    localparam logic [WORD_W-1:0] STRIDE_V = WORD_W'(STRIDE_BYTES);
    localparam logic [WORD_W-1:0] WORD1_V  = WORD_W'(WORD_BYTES);

    always_comb begin
        next_o       = take_link_i ? link_i : (cur_i + STRIDE_V);
        word1_addr_o = cur_i + WORD1_V;
    end

endmodule

// File: rtl/dcw_req_gen.sv
module dcw_req_gen
    import dcw_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int WB_FLAG_BIT = 29
) (
    input  walk_state_t       st_i,
    input  logic [WORD_W-1:0] ptr_i,
    input  logic [WORD_W-1:0] word1_addr_i,
    input  logic [WORD_W-1:0] word0_i,
    output logic              valid_o,
    output logic              write_o,
    output logic [WORD_W-1:0] addr_o,
    output logic [WORD_W-1:0] wdata_o
);

    localparam logic [WORD_W-1:0] FLAG_MASK = WORD_W'(1) << WB_FLAG_BIT;

    always_comb begin
        valid_o = 1'b0;
        write_o = 1'b0;
        addr_o  = ptr_i;
        wdata_o = word0_i | FLAG_MASK;
        case (st_i)
            WS_RD0_REQ: begin
                valid_o = 1'b1;
            end
            WS_RD1_REQ, WS_RD1_WAIT: begin
                valid_o = (st_i == WS_RD1_REQ);
                addr_o  = word1_addr_i;
            end
            WS_WB_REQ: begin
                valid_o = 1'b1;
                write_o = 1'b1;
            end
            default: begin
                valid_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/desc_chain_walker.sv
module desc_chain_walker
    import dcw_pkg::*;
#(
    parameter int WORD_W       = 32,
    parameter int STRIDE_BYTES = 8,
    parameter int WB_FLAG_BIT  = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] base_addr_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [WORD_W-1:0] last_desc_o,
    output logic              mem_req_valid_o,
    input  logic              mem_req_ready_i,
    output logic              mem_req_write_o,
    output logic [WORD_W-1:0] mem_req_addr_o,
    output logic [WORD_W-1:0] mem_req_wdata_o,
    input  logic              mem_rsp_valid_i,
    input  logic [WORD_W-1:0] mem_rsp_data_i,
    output logic              xfer_start_o,
    output logic [WORD_W-1:0] xfer_addr_o,
    input  logic              xfer_done_i
);

    localparam int TYPE_POS = WORD_W - 1;
    localparam int END_POS  = WORD_W - 2;

    typedef struct packed {
        walk_state_t       st;
        logic [WORD_W-1:0] ptr;
        logic [WORD_W-1:0] word0;
        logic [WORD_W-1:0] buf_addr;
        logic [WORD_W-1:0] last;
        logic              done;
    } walk_regs_t;

    walk_regs_t r_q, r_d;

    desc_kind_t        kind;
    logic [WORD_W-1:0] next_ptr;
    logic [WORD_W-1:0] word1_addr;
    logic              req_hs;

    dcw_decode u_decode (
        .type_bit_i (r_q.word0[TYPE_POS]),
        .end_bit_i  (r_q.word0[END_POS]),
        .kind_o     (kind)
    );

    dcw_next_ptr #(
        .WORD_W       (WORD_W),
        .STRIDE_BYTES (STRIDE_BYTES)
    ) u_next_ptr (
        .cur_i        (r_q.ptr),
        .link_i       (mem_rsp_data_i),
        .take_link_i  (kind == KIND_LINK),
        .next_o       (next_ptr),
        .word1_addr_o (word1_addr)
    );

    dcw_req_gen #(
        .WORD_W      (WORD_W),
        .WB_FLAG_BIT (WB_FLAG_BIT)
    ) u_req_gen (
        .st_i         (r_q.st),
        .ptr_i        (r_q.ptr),
        .word1_addr_i (word1_addr),
        .word0_i      (r_q.word0),
        .valid_o      (mem_req_valid_o),
        .write_o      (mem_req_write_o),
        .addr_o       (mem_req_addr_o),
        .wdata_o      (mem_req_wdata_o)
    );

    assign req_hs = mem_req_valid_o & mem_req_ready_i;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            WS_IDLE: begin
                if (start_i) begin
                    r_d.ptr = base_addr_i;
                    r_d.st  = WS_RD0_REQ;
                end
            end
            WS_RD0_REQ: begin
                if (req_hs) begin
                    r_d.st = WS_RD0_WAIT;
                end
            end
            WS_RD0_WAIT: begin
                if (mem_rsp_valid_i) begin
                    r_d.word0 = mem_rsp_data_i;
                    r_d.st    = WS_RD1_REQ;
                end
            end
            WS_RD1_REQ: begin
                if (req_hs) begin
                    r_d.st = WS_RD1_WAIT;
                end
            end
            WS_RD1_WAIT: begin
                if (mem_rsp_valid_i) begin
                    case (kind)
                        KIND_END: begin
                            r_d.st   = WS_IDLE;
                            r_d.done = 1'b1;
                        end
                        KIND_LINK: begin
                            r_d.last = r_q.ptr;
                            r_d.ptr  = next_ptr;
                            r_d.st   = WS_RD0_REQ;
                        end
                        default: begin
                            r_d.buf_addr = mem_rsp_data_i;
                            r_d.st       = WS_XFER_GO;
                        end
                    endcase
                end
            end
            WS_XFER_GO: begin
                r_d.st = WS_XFER_WAIT;
            end
            WS_XFER_WAIT: begin
                if (xfer_done_i) begin
                    r_d.st = WS_WB_REQ;
                end
            end
            WS_WB_REQ: begin
                if (req_hs) begin
                    r_d.last = r_q.ptr;
                    r_d.ptr  = next_ptr;
                    r_d.st   = WS_RD0_REQ;
                end
            end
            default: begin
                r_d.st = WS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st       <= WS_IDLE;
            r_q.ptr      <= '0;
            r_q.word0    <= '0;
            r_q.buf_addr <= '0;
            r_q.last     <= '0;
            r_q.done     <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o       = (r_q.st != WS_IDLE);
    assign done_o       = r_q.done;
    assign last_desc_o  = r_q.last;
    assign xfer_start_o = (r_q.st == WS_XFER_GO);
    assign xfer_addr_o  = r_q.buf_addr;

endmodule

// File: rtl/dcw_checker.sv
module dcw_checker #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              done_o,
    input logic [WORD_W-1:0] last_desc_o,
    input logic              mem_req_valid_o,
    input logic              mem_req_ready_i,
    input logic              mem_req_write_o,
    input logic [WORD_W-1:0] mem_req_addr_o,
    input logic              mem_rsp_valid_i,
    input logic              xfer_start_o
);

    // R10: an unaccepted request keeps its address and direction
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && !mem_req_ready_i) |=>
            (mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_write_o)));

    // R11: nothing is issued while idle
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mem_req_valid_o && !xfer_start_o));

    // R8: done is a single-cycle pulse seen with busy low
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o ##1 !done_o));

    // R6: the record moves only after an accepted write or a read response
    assert_last_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(last_desc_o) |->
            ($past(mem_req_valid_o && mem_req_ready_i && mem_req_write_o) ||
             $past(mem_rsp_valid_i)));

    // R6: after a write-back the record equals the written address
    assert_last_is_wb_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(last_desc_o) && $past(mem_req_valid_o && mem_req_ready_i && mem_req_write_o))
            |-> (last_desc_o == $past(mem_req_addr_o)));

    // R3: a transfer start lasts one cycle
    assert_xfer_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start_o |=> !xfer_start_o);

endmodule

bind desc_chain_walker dcw_checker #(.WORD_W(WORD_W)) u_dcw_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .busy_o          (busy_o),
    .done_o          (done_o),
    .last_desc_o     (last_desc_o),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_req_write_o (mem_req_write_o),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .xfer_start_o    (xfer_start_o)
);

// File: tb/desc_chain_walker_tb.sv
`timescale 1ns/1ps
module desc_chain_walker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] base_addr_i = '0;
    logic        busy_o, done_o;
    logic [31:0] last_desc_o;
    logic        mem_req_valid_o, mem_req_write_o;
    logic        mem_req_ready_i = 1'b0;
    logic [31:0] mem_req_addr_o, mem_req_wdata_o;
    logic        mem_rsp_valid_i = 1'b0;
    logic [31:0] mem_rsp_data_i = '0;
    logic        xfer_start_o;
    logic [31:0] xfer_addr_o;
    logic        xfer_done_i = 1'b0;

    always #2.5 clk = ~clk;

    desc_chain_walker u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .base_addr_i     (base_addr_i),
        .busy_o          (busy_o),
        .done_o          (done_o),
        .last_desc_o     (last_desc_o),
        .mem_req_valid_o (mem_req_valid_o),
        .mem_req_ready_i (mem_req_ready_i),
        .mem_req_write_o (mem_req_write_o),
        .mem_req_addr_o  (mem_req_addr_o),
        .mem_req_wdata_o (mem_req_wdata_o),
        .mem_rsp_valid_i (mem_rsp_valid_i),
        .mem_rsp_data_i  (mem_rsp_data_i),
        .xfer_start_o    (xfer_start_o),
        .xfer_addr_o     (xfer_addr_o),
        .xfer_done_i     (xfer_done_i)
    );

    int checks = 0;
    int errors = 0;

    logic [31:0] mem [0:255];
    logic [31:0] rd_q [$];
    logic [31:0] xf_q [$];
    logic [63:0] wb_q [$];
    logic [32:0] ls_q [$];
    logic [31:0] exp_last = '0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- memory and transfer engine models ----------------
    logic [7:0]  lfsr = 8'h5A;
    logic        pend = 1'b0;
    logic [1:0]  pend_cnt = '0;
    logic [31:0] pend_data = '0;
    int          xf_cnt = 0;

    always @(posedge clk) begin
        lfsr            <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_req_ready_i <= lfsr[0] | lfsr[2];
        mem_rsp_valid_i <= 1'b0;
        xfer_done_i     <= 1'b0;
        if (mem_req_valid_o && mem_req_ready_i) begin
            if (mem_req_write_o) begin
                mem[mem_req_addr_o[9:2]] <= mem_req_wdata_o;
            end else begin
                pend      <= 1'b1;
                pend_cnt  <= lfsr[2:1];
                pend_data <= mem[mem_req_addr_o[9:2]];
            end
        end
        if (pend) begin
            if (pend_cnt == 2'd0) begin
                mem_rsp_valid_i <= 1'b1;
                mem_rsp_data_i  <= pend_data;
                pend            <= 1'b0;
            end else begin
                pend_cnt <= pend_cnt - 2'd1;
            end
        end
        if (xfer_start_o) begin
            xf_cnt <= 3;
        end else if (xf_cnt > 0) begin
            xf_cnt <= xf_cnt - 1;
            if (xf_cnt == 1) xfer_done_i <= 1'b1;
        end
    end

    // ---------------- monitor ----------------
    logic [31:0] prev_last = '0;
    logic        prev_done = 1'b0;
    logic [31:0] last_wb_addr = 32'hFFFF_FFFF;
    int          done_seen = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req_valid_o && mem_req_ready_i) begin
                if (mem_req_write_o) begin
                    logic [63:0] e;
                    if (wb_q.size() == 0) begin
                        chk(0, "R4 unexpected write", {32'h0, mem_req_addr_o}, 64'h0);
                    end else begin
                        e = wb_q.pop_front();
                        chk({mem_req_addr_o, mem_req_wdata_o} == e, "R4 write-back addr/data",
                            {mem_req_addr_o, mem_req_wdata_o}, e);
                    end
                    last_wb_addr = mem_req_addr_o;
                end else begin
                    logic [31:0] e;
                    if (rd_q.size() == 0) begin
                        chk(0, "R2/R5/R7 unexpected read", {32'h0, mem_req_addr_o}, 64'h0);
                    end else begin
                        e = rd_q.pop_front();
                        chk(mem_req_addr_o == e, "R2/R5/R7 read address order",
                            {32'h0, mem_req_addr_o}, {32'h0, e});
                    end
                end
            end
            if (xfer_start_o) begin
                logic [31:0] e;
                if (xf_q.size() == 0) begin
                    chk(0, "R3 unexpected transfer", {32'h0, xfer_addr_o}, 64'h0);
                end else begin
                    e = xf_q.pop_front();
                    chk(xfer_addr_o == e, "R3 transfer buffer address",
                        {32'h0, xfer_addr_o}, {32'h0, e});
                end
            end
            if (last_desc_o != prev_last) begin
                logic [32:0] e;
                if (ls_q.size() == 0) begin
                    chk(0, "R6/R7 unexpected record update", {32'h0, last_desc_o}, 64'h0);
                end else begin
                    e = ls_q.pop_front();
                    chk(last_desc_o == e[31:0], "R6/R7 record value",
                        {32'h0, last_desc_o}, {32'h0, e[31:0]});
                    if (!e[32]) begin
                        chk(last_wb_addr == last_desc_o, "R6 record after write-back",
                            {32'h0, last_wb_addr}, {32'h0, last_desc_o});
                    end
                end
            end
            if (done_o) begin
                done_seen++;
                chk(!prev_done && !busy_o, "R8 done single pulse with busy low",
                    {62'h0, prev_done, busy_o}, 64'h0);
            end
            prev_last = last_desc_o;
            prev_done = done_o;
        end
    end

    // ---------------- driver ----------------
    task automatic put_desc(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1);
        mem[a[9:2]]       = w0;
        mem[a[9:2] + 8'd1] = w1;
    endtask

    task automatic model_walk(input logic [31:0] base);
        logic [31:0] p = base;
        for (int n = 0; n < 64; n++) begin
            logic [31:0] w0 = mem[p[9:2]];
            logic [31:0] w1 = mem[p[9:2] + 8'd1];
            rd_q.push_back(p);
            rd_q.push_back(p + 32'd4);
            if (w0[31] && w0[30]) begin
                break;
            end else if (w0[31]) begin
                ls_q.push_back({1'b1, p});
                exp_last = p;
                p = w1;
            end else begin
                xf_q.push_back(w1);
                wb_q.push_back({p, w0 | 32'h2000_0000});
                ls_q.push_back({1'b0, p});
                exp_last = p;
                p = p + 32'd8;
            end
        end
    endtask

    task automatic pulse_start(input logic [31:0] base);
        @(negedge clk);
        base_addr_i = base;
        start_i     = 1'b1;
        @(negedge clk);
        start_i     = 1'b0;
    endtask

    task automatic run_chain(input logic [31:0] base, input string tag, input bit poke);
        int d0 = done_seen;
        int cyc = 0;
        model_walk(base);
        pulse_start(base);
        chk(busy_o == 1'b1, "R11 busy after start", {63'h0, busy_o}, 64'h1);
        if (poke) begin
            repeat (10) @(negedge clk);
            chk(busy_o == 1'b1, "R9 still busy before second start", {63'h0, busy_o}, 64'h1);
            pulse_start(32'h0000_03F0);
        end
        while (busy_o && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc < 5000, {tag, " R11 walk halts"}, cyc, 64'd0);
        @(negedge clk);
        chk(done_seen == d0 + 1, {tag, " R8 one done pulse"}, done_seen - d0, 64'd1);
        chk(last_desc_o == exp_last, {tag, " R6/R7/R8 final record"}, {32'h0, last_desc_o}, {32'h0, exp_last});
        chk(rd_q.size() == 0 && xf_q.size() == 0 && wb_q.size() == 0 && ls_q.size() == 0,
            {tag, " R2/R3/R4 all expected events seen"},
            rd_q.size() + xf_q.size() + wb_q.size() + ls_q.size(), 64'd0);
        rd_q.delete(); xf_q.delete(); wb_q.delete(); ls_q.delete();
        repeat (3) @(negedge clk);
        chk(!mem_req_valid_o && !xfer_start_o && !busy_o, {tag, " R11 quiet when idle"},
            {61'h0, mem_req_valid_o, xfer_start_o, busy_o}, 64'h0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hC000_0000;
        // chain A: sequential data entries, one with bit 30 set and bit 31 clear
        put_desc(32'h100, 32'h0000_05A1, 32'h1000_0000);
        put_desc(32'h108, 32'h4000_0123, 32'h1000_0040);
        put_desc(32'h110, 32'h0000_0777, 32'h1000_0080);
        put_desc(32'h118, 32'hC000_0000, 32'h0);
        // chain B: data, link, data, data, end
        put_desc(32'h200, 32'h0000_0011, 32'h2000_0000);
        put_desc(32'h208, 32'h8000_0000, 32'h0000_0300);
        put_desc(32'h300, 32'h0000_0022, 32'h2000_1000);
        put_desc(32'h308, 32'h0000_0033, 32'h2000_2000);
        put_desc(32'h310, 32'hC000_0000, 32'h0);
        // chain C: link, link, end
        put_desc(32'h040, 32'h8000_0000, 32'h0000_0080);
        put_desc(32'h080, 32'h8000_0000, 32'h0000_00C0);
        put_desc(32'h0C0, 32'hC000_0000, 32'h0);
        // chain D: end at the start
        put_desc(32'h3F0, 32'hC000_0000, 32'h0);

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(last_desc_o == 32'h0, "R1 record reset value", {32'h0, last_desc_o}, 64'h0);
        chk(!busy_o && !done_o, "R1 busy/done low", {62'h0, busy_o, done_o}, 64'h0);
        chk(!mem_req_valid_o && !xfer_start_o, "R1 no request", {62'h0, mem_req_valid_o, xfer_start_o}, 64'h0);

        run_chain(32'h100, "chainA", 1'b0);
        run_chain(32'h200, "chainB R9", 1'b1);
        run_chain(32'h040, "chainC R7", 1'b0);
        run_chain(32'h3F0, "chainD R8", 1'b0);
        chk(last_desc_o == 32'h080, "R8 record kept at end-only chain", {32'h0, last_desc_o}, 64'h80);
        run_chain(32'h100, "chainA rerun", 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule